// File: doc/BRIEF.md
# Parallel Bus Master Port

This block connects an internal memory-mapped request port to an external asynchronous parallel bus. Memories, FIFOs, display controllers or other processors sit on that bus. Two address windows are decoded from the internal address, and each window owns one chip-select line. A request that lands inside a window runs one or more external bus cycles on that window's select line. A request that lands in neither window is ignored.

Every chip select has its own configuration inputs, and these are held static while the port is busy:
- strobe style: separate read and write strobes, or a direction line together with an enable strobe
- active level of its select line, its strobes and its acknowledge input
- data wait count
- whether it waits for an external acknowledge

The following settings are shared by both chip selects:
- the external data width (4, 8 or 16 lanes)
- address/data multiplexing
- the address wait count

A 16-bit access on a narrower bus is split into several external beats, lowest part first. The data lines are modelled as a driven value plus an output enable: enable low means tri-stated.

Top module: `pbm_port`

## Requirements
- R1: With the default windows, an address whose upper two bits are `10` selects chip select 0 and `11` selects chip select 1. Only that select line goes active, and it stays active for the whole beat. Any other address starts no bus activity and no done pulse. The external address is the low 22 bits of the internal address.
- R2: In separate-strobe style, a read drives `bus_sa` active and leaves `bus_sb` inactive. A write drives `bus_sb` active and leaves `bus_sa` inactive. During a write data phase the data lines carry the write data with `bus_doe` high. During a read data phase `bus_doe` stays low.
- R3: In combined style (the `cfg_strobe_comb` bit of the chip select is 1), `bus_sa` is a direction level during the address and data phases: 1 for read and 0 for write. It rests at 1 otherwise. `bus_sb` is the enable strobe, active only in the data phase.
- R4: `cfg_pol` bit i = 1 makes chip select i, the strobes used for it, and its acknowledge input active-high. A value of 0 makes them active-low. Between cycles, the strobes rest at the inactive level of the chip select used last.
- R5: Each beat starts with an address phase of `cfg_await`+1 cycles. In that phase the select line and the address are driven and no strobe is active. The data phase that follows keeps the strobe active for `cfg_dwait`(cs)+1 cycles when acknowledge is disabled. `cfg_dwait` holds 4 bits per chip select, with chip select 0 in the low nibble.
- R6: With `cfg_mux`=1, `bus_ale` is high for exactly the address-phase cycles. During those cycles the data lines carry the low 16 address bits with `bus_doe` high. The data phase then carries data.
- R7: With acknowledge enabled for a chip select, the data phase lasts until both the wait count has run out and acknowledge is seen at its active level. Read data is sampled in the cycle that acknowledge is accepted.
- R8: If acknowledge never arrives, the data phase ends after `cfg_dwait`+256 cycles. The done pulse then comes with `rsp_err`=1. The next successful request clears `rsp_err`.
- R9: `cfg_width` selects the bus width: `00` is 8 bits, `01` is 16 bits, `10` is 4 bits. An access (`req_size` 0 = byte, 1 = 16-bit) wider than the bus is split into beats, lowest lanes first. The address increases by one per beat. Read data is assembled in the same order, and a byte read returns zero in its upper byte.
- R10: Every beat is followed by at least one cycle with all selects inactive, `bus_doe` low and `bus_ale` low.
- R11: `rsp_done` is a one-cycle pulse issued once per request, in the cycle after the last beat's gap. `req_ready` is low while a request is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Internal request present |
| req_ready | output | 1 | Port can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 1 | 0 = byte, 1 = 16-bit |
| req_addr | input | 24 | Internal address |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | Request finished (pulse) |
| rsp_rdata | output | 16 | Assembled read data |
| rsp_err | output | 1 | Acknowledge timeout on the last request |
| cfg_width | input | 2 | External bus width code |
| cfg_mux | input | 1 | Address/data multiplexing enable |
| cfg_await | input | 4 | Address wait count |
| cfg_strobe_comb | input | 2 | Per chip select: combined strobe style |
| cfg_pol | input | 2 | Per chip select: active-high controls |
| cfg_ack_en | input | 2 | Per chip select: wait for acknowledge |
| cfg_dwait | input | 8 | Per chip select data wait counts |
| bus_cs | output | 2 | Chip-select lines |
| bus_addr | output | 23 | External address lines |
| bus_ale | output | 1 | Address latch strobe (active high) |
| bus_sa | output | 1 | Read strobe or direction line |
| bus_sb | output | 1 | Write strobe or enable strobe |
| bus_dout | output | 16 | Data lines, driven value |
| bus_doe | output | 1 | Data lines output enable |
| bus_din | input | 16 | Data lines, sampled value |
| bus_ack | input | 2 | Per chip select acknowledge |

## Verification
The bench builds the port with its defaults: two chip selects, 22-bit windows based at 0x800000 and 0xC00000, 4-bit wait counters and a 255-cycle acknowledge limit. It reprograms the static configuration inputs between directed scenarios. With this build, all three bus widths, both strobe styles, mixed polarities and a full acknowledge timeout of several hundred cycles can be reached within a short run. A bench-side device model returns data derived from the address and raises acknowledge after a chosen number of strobe cycles. This lets the bench predict every beat length and every assembled read word.

// File: rtl/pbm_pkg.sv
package pbm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_GAP  = 2'd3
  } pbm_state_e;

  localparam logic [1:0] BW_8  = 2'b00;
  localparam logic [1:0] BW_16 = 2'b01;
  localparam logic [1:0] BW_4  = 2'b10;

  // number of lanes per beat for a width code
  function automatic logic [4:0] lane_bits(input logic [1:0] w);
    case (w)
      BW_16:   return 5'd16;
      BW_4:    return 5'd4;
      default: return 5'd8;
    endcase
  endfunction

  // index of the final beat for an access size and width code
  function automatic logic [1:0] last_beat(input logic half, input logic [1:0] w);
    if (half) begin
      case (w)
        BW_16:   return 2'd0;
        BW_4:    return 2'd3;
        default: return 2'd1;
      endcase
    end
    return (w == BW_4) ? 2'd1 : 2'd0;
  endfunction
endpackage

// File: rtl/pbm_decode.sv
module pbm_decode #(
  parameter int IAW      = 24,
  parameter int WIN_BITS = 22,
  parameter int NCS      = 2,
  parameter int CSW      = 1,
  parameter logic [NCS*IAW-1:0] BASES = '0
) (
  input  logic [IAW-1:0] addr,
  output logic           hit,
  output logic [CSW-1:0] sel
);
  localparam int TAGW = IAW - WIN_BITS;

  logic [NCS-1:0] match;

  for (genvar g = 0; g < NCS; g++) begin : g_win
    assign match[g] = (addr[IAW-1:WIN_BITS] == BASES[g*IAW+WIN_BITS +: TAGW]);
  end

  always_comb begin
    hit = |match;
    sel = '0;
    for (int i = NCS - 1; i >= 0; i--) begin
      if (match[i]) sel = CSW'(i);
    end
  end
endmodule

// File: rtl/pbm_seq.sv
module pbm_seq
  import pbm_pkg::*;
#(
  parameter int EAW = 23,
  parameter int DW  = 16,
  parameter int NCS = 2,
  parameter int CSW = 1,
  parameter int AWW = 4,
  parameter int DWW = 4,
  parameter int TMO = 255
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CSW-1:0]   start_cs,
  input  logic             start_wr,
  input  logic             start_half,
  input  logic [EAW-1:0]   start_off,
  input  logic [DW-1:0]    start_wdata,
  input  logic [1:0]       cfg_width,
  input  logic [AWW-1:0]   cfg_await,
  input  logic [NCS*DWW-1:0] cfg_dwait,
  input  logic [NCS-1:0]   cfg_ack_en,
  input  logic             ack_act,
  input  logic [DW-1:0]    din,
  output pbm_state_e       state,
  output logic [CSW-1:0]   cur_cs,
  output logic             cur_wr,
  output logic [EAW-1:0]   cur_addr,
  output logic [DW-1:0]    beat_wdata,
  output logic             done,
  output logic [DW-1:0]    rdata,
  output logic             err
);
  localparam int CW = (AWW > DWW) ? AWW : DWW;
  localparam int TW = $clog2(TMO + 1);

  pbm_state_e     st_q, st_d;
  logic [CSW-1:0] cs_q, cs_d;
  logic           wr_q, wr_d, half_q, half_d;
  logic [EAW-1:0] addr_q, addr_d;
  logic [DW-1:0]  wdata_q, wdata_d, rdata_q, rdata_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [TW-1:0]  tmo_q, tmo_d;
  logic [1:0]     beat_q, beat_d, nb_q, nb_d, width_q, width_d;
  logic           done_q, done_d, err_q, err_d;

  logic [4:0]     lw;
  logic [5:0]     shamt;
  logic [DW-1:0]  lmask, smask, merged;
  logic [DWW-1:0] dw_sel;

  assign lw      = lane_bits(width_q);
  assign lmask   = DW'((32'd1 << lw) - 32'd1);
  assign shamt   = {4'b0, beat_q} * {1'b0, lw};
  assign smask   = half_q ? '1 : DW'(8'hFF);
  assign merged  = rdata_q | (((din & lmask) << shamt) & smask);
  assign dw_sel  = cfg_dwait[cs_q*DWW +: DWW];

  always_comb begin
    st_d = st_q;  cs_d = cs_q;  wr_d = wr_q;  half_d = half_q;
    addr_d = addr_q;  wdata_d = wdata_q;  rdata_d = rdata_q;
    cnt_d = cnt_q;  tmo_d = tmo_q;  beat_d = beat_q;  nb_d = nb_q;
    width_d = width_q;  err_d = err_q;  done_d = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d    = ST_ADDR;
          cs_d    = start_cs;
          wr_d    = start_wr;
          half_d  = start_half;
          addr_d  = start_off;
          wdata_d = start_half ? start_wdata : (start_wdata & DW'(8'hFF));
          rdata_d = '0;
          err_d   = 1'b0;
          cnt_d   = CW'(cfg_await);
          beat_d  = 2'd0;
          nb_d    = last_beat(start_half, cfg_width);
          width_d = cfg_width;
        end
      end
      ST_ADDR: begin
        if (cnt_q == '0) begin
          st_d  = ST_DATA;
          cnt_d = CW'(dw_sel);
          tmo_d = '0;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_DATA: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - 1'b1;
        end else if (!cfg_ack_en[cs_q] || ack_act) begin
          st_d = ST_GAP;
          if (!wr_q) rdata_d = merged;
        end else if (tmo_q == TW'(TMO)) begin
          st_d  = ST_GAP;
          err_d = 1'b1;
          if (!wr_q) rdata_d = merged;
        end else begin
          tmo_d = tmo_q + 1'b1;
        end
      end
      ST_GAP: begin
        if (beat_q == nb_q) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end else begin
          st_d   = ST_ADDR;
          beat_d = beat_q + 1'b1;
          addr_d = addr_q + 1'b1;
          cnt_d  = CW'(cfg_await);
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;  cs_q <= '0;  wr_q <= 1'b0;  half_q <= 1'b0;
      addr_q <= '0;  wdata_q <= '0;  rdata_q <= '0;  cnt_q <= '0;
      tmo_q <= '0;  beat_q <= '0;  nb_q <= '0;  width_q <= '0;
      done_q <= 1'b0;  err_q <= 1'b0;
    end else begin
      st_q <= st_d;  cs_q <= cs_d;  wr_q <= wr_d;  half_q <= half_d;
      addr_q <= addr_d;  wdata_q <= wdata_d;  rdata_q <= rdata_d;  cnt_q <= cnt_d;
      tmo_q <= tmo_d;  beat_q <= beat_d;  nb_q <= nb_d;  width_q <= width_d;
      done_q <= done_d;  err_q <= err_d;
    end
  end

  assign state      = st_q;
  assign cur_cs     = cs_q;
  assign cur_wr     = wr_q;
  assign cur_addr   = addr_q;
  assign beat_wdata = (wdata_q >> shamt) & lmask;
  assign done       = done_q;
  assign rdata      = rdata_q;
  assign err        = err_q;
endmodule

// File: rtl/pbm_pins.sv
module pbm_pins
  import pbm_pkg::*;
#(
  parameter int EAW = 23,
  parameter int DW  = 16,
  parameter int NCS = 2,
  parameter int CSW = 1
) (
  input  pbm_state_e     state,
  input  logic [CSW-1:0] cs,
  input  logic           wr,
  input  logic [EAW-1:0] addr,
  input  logic [DW-1:0]  wdata,
  input  logic           cfg_mux,
  input  logic [NCS-1:0] cfg_comb,
  input  logic [NCS-1:0] cfg_pol,
  output logic [NCS-1:0] bus_cs,
  output logic [EAW-1:0] bus_addr,
  output logic           bus_ale,
  output logic           bus_sa,
  output logic           bus_sb,
  output logic [DW-1:0]  bus_dout,
  output logic           bus_doe
);
  logic in_cyc, dph, aph_mux, p;

  assign in_cyc  = (state == ST_ADDR) || (state == ST_DATA);
  assign dph     = (state == ST_DATA);
  assign aph_mux = (state == ST_ADDR) && cfg_mux;
  assign p       = cfg_pol[cs];

  for (genvar g = 0; g < NCS; g++) begin : g_cs
    assign bus_cs[g] = (in_cyc && cs == CSW'(g)) ? cfg_pol[g] : ~cfg_pol[g];
  end

  always_comb begin
    if (cfg_comb[cs]) begin
      bus_sa = in_cyc ? ~wr : 1'b1;
      bus_sb = dph ? p : ~p;
    end else begin
      bus_sa = (dph && !wr) ? p : ~p;
      bus_sb = (dph && wr) ? p : ~p;
    end
    bus_ale  = aph_mux;
    bus_doe  = aph_mux || (dph && wr);
    bus_dout = aph_mux ? addr[DW-1:0] : ((dph && wr) ? wdata : '0);
    bus_addr = addr;
  end
endmodule

// File: rtl/pbm_port.sv
module pbm_port
  import pbm_pkg::*;
#(
  parameter int IAW      = 24,
  parameter int EAW      = 23,
  parameter int DW       = 16,
  parameter int NCS      = 2,
  parameter int WIN_BITS = 22,
  parameter logic [NCS*IAW-1:0] WIN_BASES = {24'hC00000, 24'h800000},
  parameter int AWW      = 4,
  parameter int DWW      = 4,
  parameter int TMO      = 255
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic               req_size,
  input  logic [IAW-1:0]     req_addr,
  input  logic [DW-1:0]      req_wdata,
  output logic               rsp_done,
  output logic [DW-1:0]      rsp_rdata,
  output logic               rsp_err,
  input  logic [1:0]         cfg_width,
  input  logic               cfg_mux,
  input  logic [AWW-1:0]     cfg_await,
  input  logic [NCS-1:0]     cfg_strobe_comb,
  input  logic [NCS-1:0]     cfg_pol,
  input  logic [NCS-1:0]     cfg_ack_en,
  input  logic [NCS*DWW-1:0] cfg_dwait,
  output logic [NCS-1:0]     bus_cs,
  output logic [EAW-1:0]     bus_addr,
  output logic               bus_ale,
  output logic               bus_sa,
  output logic               bus_sb,
  output logic [DW-1:0]      bus_dout,
  output logic               bus_doe,
  input  logic [DW-1:0]      bus_din,
  input  logic [NCS-1:0]     bus_ack
);
  localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1;

  logic [1:0]     rst_sync_q;
  logic           rst_i, hit, start, ack_act, cur_wr;
  logic [CSW-1:0] sel, cur_cs;
  logic [EAW-1:0] cur_addr;
  logic [DW-1:0]  beat_wdata;
  pbm_state_e     state;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  pbm_decode #(.IAW(IAW), .WIN_BITS(WIN_BITS), .NCS(NCS), .CSW(CSW), .BASES(WIN_BASES)) u_dec (
    .addr(req_addr), .hit(hit), .sel(sel)
  );

  assign req_ready = (state == ST_IDLE) && rst_i;
  assign start     = req_valid && req_ready && hit;
  assign ack_act   = (bus_ack[cur_cs] == cfg_pol[cur_cs]);

  pbm_seq #(.EAW(EAW), .DW(DW), .NCS(NCS), .CSW(CSW), .AWW(AWW), .DWW(DWW), .TMO(TMO)) u_seq (
    .clk(clk), .rst_n(rst_i), .start(start), .start_cs(sel), .start_wr(req_write),
    .start_half(req_size), .start_off(EAW'(req_addr[WIN_BITS-1:0])), .start_wdata(req_wdata),
    .cfg_width(cfg_width), .cfg_await(cfg_await), .cfg_dwait(cfg_dwait), .cfg_ack_en(cfg_ack_en),
    .ack_act(ack_act), .din(bus_din), .state(state), .cur_cs(cur_cs), .cur_wr(cur_wr),
    .cur_addr(cur_addr), .beat_wdata(beat_wdata), .done(rsp_done), .rdata(rsp_rdata), .err(rsp_err)
  );

  pbm_pins #(.EAW(EAW), .DW(DW), .NCS(NCS), .CSW(CSW)) u_pins (
    .state(state), .cs(cur_cs), .wr(cur_wr), .addr(cur_addr), .wdata(beat_wdata),
    .cfg_mux(cfg_mux), .cfg_comb(cfg_strobe_comb), .cfg_pol(cfg_pol),
    .bus_cs(bus_cs), .bus_addr(bus_addr), .bus_ale(bus_ale), .bus_sa(bus_sa),
    .bus_sb(bus_sb), .bus_dout(bus_dout), .bus_doe(bus_doe)
  );
endmodule

// File: rtl/pbm_port_chk.sv
module pbm_port_chk #(
  parameter int NCS = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_ready,
  input logic           rsp_done,
  input logic           cfg_mux,
  input logic [NCS-1:0] cfg_pol,
  input logic [NCS-1:0] bus_cs,
  input logic           bus_ale,
  input logic           bus_doe
);
  logic [NCS-1:0] cs_act;
  logic           any_cs;

  assign cs_act = ~(bus_cs ^ cfg_pol);
  assign any_cs = |cs_act;

  p_one_cs_r1: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(cs_act));
  p_cs_steady_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (any_cs && $past(any_cs)) |-> $stable(cs_act));
  p_ale_mux_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |-> (cfg_mux && bus_doe && any_cs));
  p_quiet_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !any_cs |-> (!bus_doe && !bus_ale));
  p_done_after_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> !any_cs);
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  p_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    any_cs |-> !req_ready);
endmodule

bind pbm_port pbm_port_chk #(.NCS(NCS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_done(rsp_done),
  .cfg_mux(cfg_mux), .cfg_pol(cfg_pol), .bus_cs(bus_cs), .bus_ale(bus_ale), .bus_doe(bus_doe)
);

// File: tb/sim_pbm_port.sv
module sim_pbm_port;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic        rst_n, req_valid, req_ready, req_write, req_size;
  logic [23:0] req_addr;
  logic [15:0] req_wdata, rsp_rdata, bus_dout, bus_din;
  logic        rsp_done, rsp_err, cfg_mux, bus_ale, bus_sa, bus_sb, bus_doe;
  logic [1:0]  cfg_width, cfg_strobe_comb, cfg_pol, cfg_ack_en, bus_cs, bus_ack;
  logic [3:0]  cfg_await;
  logic [7:0]  cfg_dwait;
  logic [22:0] bus_addr;

  pbm_port u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .cfg_width(cfg_width),
    .cfg_mux(cfg_mux), .cfg_await(cfg_await), .cfg_strobe_comb(cfg_strobe_comb),
    .cfg_pol(cfg_pol), .cfg_ack_en(cfg_ack_en), .cfg_dwait(cfg_dwait), .bus_cs(bus_cs),
    .bus_addr(bus_addr), .bus_ale(bus_ale), .bus_sa(bus_sa), .bus_sb(bus_sb),
    .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din), .bus_ack(bus_ack)
  );

  int errs = 0, checks = 0, ntr = 0;
  logic        cur_s;
  logic [1:0]  tr_cs [600];
  logic        tr_sa [600], tr_sb [600], tr_ale [600], tr_doe [600], tr_done [600], tr_rdy [600];
  logic [22:0] tr_addr [600];
  logic [15:0] tr_dout [600];

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [15:0] dev_data(input logic [22:0] a);
    return {a[7:0] ^ 8'h3C, a[7:0] + 8'h01};
  endfunction

  function automatic bit strobe_on(input int i);
    if (cfg_strobe_comb[cur_s]) return tr_sb[i] == cfg_pol[cur_s];
    return (tr_sa[i] == cfg_pol[cur_s]) || (tr_sb[i] == cfg_pol[cur_s]);
  endfunction

  function automatic int n_strobe();
    int n = 0;
    for (int i = 0; i < ntr; i++) if (strobe_on(i)) n++;
    return n;
  endfunction

  function automatic int first_strobe();
    for (int i = 0; i < ntr; i++) if (strobe_on(i)) return i;
    return -1;
  endfunction

  function automatic int n_ale();
    int n = 0;
    for (int i = 0; i < ntr; i++) if (tr_ale[i]) n++;
    return n;
  endfunction

  function automatic int n_done();
    int n = 0;
    for (int i = 0; i < ntr; i++) if (tr_done[i]) n++;
    return n;
  endfunction

  // issue one request and record the pins once per cycle until done
  task automatic run_acc(input bit wr, input bit half, input logic [23:0] a,
                         input logic [15:0] wd, input int ack_after);
    int dc = 0;
    bit fin = 0;
    cur_s = a[22];
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = half; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    ntr = 0;
    while (!fin && ntr < 600) begin
      tr_cs[ntr] = bus_cs;  tr_sa[ntr] = bus_sa;  tr_sb[ntr] = bus_sb;
      tr_ale[ntr] = bus_ale;  tr_doe[ntr] = bus_doe;  tr_done[ntr] = rsp_done;
      tr_rdy[ntr] = req_ready;  tr_addr[ntr] = bus_addr;  tr_dout[ntr] = bus_dout;
      if (rsp_done) fin = 1;
      if (strobe_on(ntr)) dc++; else dc = 0;
      bus_din = dev_data(bus_addr);
      bus_ack = ~cfg_pol;
      if (ack_after >= 0 && dc > ack_after) bus_ack[cur_s] = cfg_pol[cur_s];
      ntr++;
      if (!fin) @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk("R11 ready after reset", req_ready, 1);
    chk("R10 selects idle after reset", bus_cs, 2'b11);
    chk("R10 data off after reset", {bus_doe, rsp_done}, 2'b00);
  endtask

  task automatic t_separate;
    run_acc(1, 1, 24'h800123, 16'hBEEF, -1);
    chk("R1 cs0 selected", tr_cs[0], 2'b10);
    chk("R1 external address", tr_addr[0], 23'h000123);
    chk("R5 address phase length", first_strobe(), 3);
    chk("R5 strobe length", n_strobe(), 4);
    chk("R2 write uses write strobe", {tr_sa[3], tr_sb[3]}, 2'b10);
    chk("R2 write data driven", {tr_doe[3], tr_dout[3]}, {1'b1, 16'hBEEF});
    chk("R10 gap after beat", {tr_cs[7], tr_doe[7]}, 3'b110);
    chk("R11 busy not ready", tr_rdy[2], 0);
    chk("R11 single done at end", {n_done(), ntr}, {32'd1, 32'd9});
    run_acc(0, 1, 24'h800040, 16'h0, -1);
    chk("R2 read uses read strobe", {tr_sa[3], tr_sb[3], tr_doe[3]}, 3'b010);
    chk("R2 read data", rsp_rdata, 16'h7C41);
  endtask

  task automatic t_decode;
    int bad = 0;
    run_acc(0, 1, 24'hC00010, 16'h0, -1);
    chk("R1 cs1 selected", tr_cs[0], 2'b01);
    chk("R5 cs1 own data wait", n_strobe(), 2);
    chk("R1 cs1 read data", rsp_rdata, 16'h2C11);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 24'h400010;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (bus_cs != 2'b11 || rsp_done || !req_ready) bad++;
      @(negedge clk);
    end
    chk("R1 outside windows ignored", bad, 0);
  endtask

  task automatic t_combined;
    cfg_strobe_comb = 2'b01;
    run_acc(1, 1, 24'h800008, 16'h1234, -1);
    chk("R3 write direction in address phase", {tr_sa[0], tr_sb[0]}, 2'b01);
    chk("R3 enable in data phase", {tr_sa[3], tr_sb[3]}, 2'b00);
    chk("R3 enable length", n_strobe(), 4);
    chk("R3 rest level", {tr_sa[ntr-1], tr_sb[ntr-1]}, 2'b11);
    run_acc(0, 1, 24'h800009, 16'h0, -1);
    chk("R3 read direction", {tr_sa[3], tr_sb[3]}, 2'b10);
    chk("R3 read data", rsp_rdata, 16'h350A);
    cfg_strobe_comb = 2'b00;
  endtask

  task automatic t_polarity;
    cfg_pol = 2'b10;
    @(negedge clk);
    run_acc(0, 1, 24'hC00020, 16'h0, -1);
    chk("R4 active-high select", tr_cs[0], 2'b11);
    chk("R4 active-high read strobe", tr_sa[3], 1);
    chk("R4 strobe count", n_strobe(), 2);
    chk("R4 idle levels after cs1", {tr_cs[ntr-1], tr_sa[ntr-1], tr_sb[ntr-1]}, 4'b0100);
    chk("R4 read data", rsp_rdata, 16'h1C21);
    cfg_ack_en = 2'b10;
    run_acc(0, 1, 24'hC00024, 16'h0, 3);
    chk("R4 active-high acknowledge", n_strobe(), 4);
    cfg_ack_en = 2'b00;
    cfg_pol = 2'b00;
    @(negedge clk);
  endtask

  task automatic t_mux;
    cfg_mux = 1'b1;
    run_acc(1, 1, 24'h801234, 16'h00C3, -1);
    chk("R6 latch strobe length", n_ale(), 3);
    chk("R6 address on data lines", {tr_doe[0], tr_dout[0]}, {1'b1, 16'h1234});
    chk("R6 data phase", {tr_ale[3], tr_dout[3]}, {1'b0, 16'h00C3});
    cfg_mux = 1'b0;
  endtask

  task automatic t_ack;
    cfg_ack_en = 2'b01;
    run_acc(0, 1, 24'h800060, 16'h0, 6);
    chk("R7 held for acknowledge", n_strobe(), 7);
    chk("R7 read data", {rsp_err, rsp_rdata}, {1'b0, 16'h5C61});
    run_acc(0, 1, 24'h800060, 16'h0, 0);
    chk("R7 waits still honoured", n_strobe(), 4);
    run_acc(0, 1, 24'h800062, 16'h0, -1);
    chk("R8 timeout length", n_strobe(), 259);
    chk("R8 error flag", {rsp_err, tr_done[ntr-1]}, 2'b11);
    run_acc(0, 1, 24'h800062, 16'h0, 1);
    chk("R8 error cleared", {rsp_err, n_strobe()}, {1'b0, 32'd4});
    cfg_ack_en = 2'b00;
  endtask

  task automatic t_split;
    cfg_width = 2'b00;
    run_acc(1, 1, 24'h800100, 16'hA55A, -1);
    chk("R9 low byte first", {tr_addr[3], tr_dout[3]}, {23'h000100, 16'h005A});
    chk("R9 high byte next", {tr_addr[11], tr_dout[11]}, {23'h000101, 16'h00A5});
    chk("R9 two beats", n_strobe(), 8);
    chk("R10 gap between beats", {tr_cs[7], tr_doe[7]}, 3'b110);
    chk("R11 done only after second beat", {n_done(), ntr}, {32'd1, 32'd17});
    run_acc(0, 1, 24'h800200, 16'h0, -1);
    chk("R9 8-bit read assembly", rsp_rdata, 16'h0201);
    cfg_width = 2'b10;
    run_acc(0, 1, 24'h800300, 16'h0, -1);
    chk("R9 4-bit read assembly", {rsp_rdata, ntr}, {16'h4321, 32'd33});
    run_acc(0, 0, 24'h800310, 16'h0, -1);
    chk("R9 4-bit byte read", rsp_rdata, 16'h0021);
    cfg_width = 2'b01;
    run_acc(0, 0, 24'h800050, 16'h0, -1);
    chk("R9 byte read upper zero", {rsp_rdata, n_strobe()}, {16'h0051, 32'd4});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_size = 1'b0;
    req_addr = '0; req_wdata = '0; bus_din = '0; bus_ack = 2'b11;
    cfg_width = 2'b01; cfg_mux = 1'b0; cfg_await = 4'd2; cfg_strobe_comb = 2'b00;
    cfg_pol = 2'b00; cfg_ack_en = 2'b00; cfg_dwait = {4'd1, 4'd3};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_separate();
    t_decode();
    t_combined();
    t_polarity();
    t_mux();
    t_ack();
    t_split();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule